// File: doc/BRIEF.md
# Scan Counter with Pretrigger Reload

This block counts finished scans and decides when an acquisition run ends. The host writes two 24-bit start values. The posttrigger value goes into one register and the pretrigger value into the other. Each value is written as the wanted scan count minus one. A load strobe copies one of the two values into the down-counter. An arm strobe then starts the run, and each end-of-scan pulse that arrives while the run is active is counted.

There are two modes. In posttrigger mode the run ends when the counter's count is used up. In pretrigger mode the counter keeps reloading its pretrigger value and the run goes on. Once one full pretrigger count has passed, a trigger pulse switches the counter to the posttrigger value, and the run then ends when that count is used up. A disarm strobe ends a run at any time. All pins are plain control and status levels or pulses. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `scan_counter`

## Requirements
- R1: After reset, `acq_active`, `tc_pulse` and `stop_req` are all low.
- R2: A start value of N-1 gives exactly N counted scans. The N-th accepted `scan_end` raises `tc_pulse` for one cycle, on the clock edge that samples that `scan_end`. The pulse is then visible until the next edge.
- R3: In the posttrigger phase, the terminal scan raises `stop_req` for one cycle together with `tc_pulse`. `acq_active` drops on the same edge.
- R4: In the pretrigger phase, the terminal scan pulses `tc_pulse` without `stop_req`. The counter reloads the pretrigger value and `acq_active` stays high.
- R5: A `trigger` in the pretrigger phase is taken only after at least one terminal scan of that phase. Taking it loads the posttrigger value and enters the posttrigger phase. Earlier triggers, and triggers while not armed, are ignored.
- R6: `disarm_stb` has priority over every other input. If the block was armed, `acq_active` drops on the next edge and `stop_req` pulses for one cycle.
- R7: `scan_end` is ignored while `acq_active` is low.
- R8: `load_stb` is ignored while `acq_active` is high.
- R9: When not armed, `load_stb` loads the pretrigger value if `pre_mode`=1 and the posttrigger value if `pre_mode`=0, and sets the phase to match. `arm_stb` raises `acq_active` on the next edge. Load and arm in the same cycle are both performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_data | input | 24 | Start value (scan count minus one) for a register write |
| wr_post | input | 1 | Write `load_data` into the posttrigger register |
| wr_pre | input | 1 | Write `load_data` into the pretrigger register |
| load_stb | input | 1 | Copy the selected register into the counter |
| arm_stb | input | 1 | Start counting |
| disarm_stb | input | 1 | Abort the run |
| pre_mode | input | 1 | 1 = pretrigger mode, 0 = posttrigger mode (sampled on load) |
| scan_end | input | 1 | One pulse per finished scan |
| trigger | input | 1 | Trigger pulse |
| acq_active | output | 1 | Run in progress (armed) |
| tc_pulse | output | 1 | Terminal-count pulse |
| stop_req | output | 1 | One-cycle request to end the acquisition |

## Verification
The assertions assume that the strobes are single-cycle pulses. They also assume that `trigger` and `scan_end` never fall in the same cycle. The design settles that case in favour of the trigger, which drops that scan, but no property depends on it. The stimulus drives each strobe for exactly one clock and keeps triggers and scans in separate cycles. It also issues loads both while armed and while idle, so that the ignore rules are exercised.

// File: rtl/scnt_pkg.sv
package scnt_pkg;
  typedef enum logic {
    PH_POST = 1'b0,
    PH_PRE  = 1'b1
  } phase_e;

  localparam int unsigned SCNT_W = 24;
endpackage

// File: rtl/scnt_load_regs.sv
module scnt_load_regs #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   wr_en,    // [0] posttrigger, [1] pretrigger
  output logic [W-1:0] val_post,
  output logic [W-1:0] val_pre
);
  localparam int unsigned NREG = 2;

  logic [W-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)        regs[i] <= '0;
      else if (wr_en[i]) regs[i] <= wr_data;
    end
  end

  assign val_post = regs[0];
  assign val_pre  = regs[1];
endmodule

// File: rtl/scnt_counter.sv
module scnt_counter #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         zero
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (dec) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // the decrement path never wraps below zero
  p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !ld && !zero) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/scnt_ctrl.sv
module scnt_ctrl
  import scnt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_stb,
  input  logic arm_stb,
  input  logic disarm_stb,
  input  logic pre_mode,
  input  logic scan_end,
  input  logic trigger,
  input  logic cnt_zero,
  output logic ld,
  output logic ld_sel_pre,
  output logic dec,
  output logic armed,
  output logic tc,
  output logic stop
);
  phase_e phase;
  logic   pre_done;
  logic   acc_trig, scan_ok, ev_term, ev_load;

  always_comb begin
    acc_trig   = !disarm_stb && armed && trigger && (phase == PH_PRE) && pre_done;
    scan_ok    = !disarm_stb && armed && scan_end && !acc_trig;
    ev_term    = scan_ok && cnt_zero;
    dec        = scan_ok && !cnt_zero;
    ev_load    = !disarm_stb && !armed && load_stb;
    ld         = ev_load || acc_trig || (ev_term && (phase == PH_PRE));
    ld_sel_pre = ev_load ? pre_mode : !acc_trig;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      phase    <= PH_POST;
      pre_done <= 1'b0;
      tc       <= 1'b0;
      stop     <= 1'b0;
    end else begin
      tc   <= ev_term;
      stop <= 1'b0;
      if (disarm_stb) begin
        armed <= 1'b0;
        stop  <= armed;
      end else if (armed) begin
        if (acc_trig) begin
          phase <= PH_POST;
        end else if (ev_term) begin
          if (phase == PH_PRE) begin
            pre_done <= 1'b1;
          end else begin
            armed <= 1'b0;
            stop  <= 1'b1;
          end
        end
      end else begin
        if (load_stb) begin
          phase    <= pre_mode ? PH_PRE : PH_POST;
          pre_done <= 1'b0;
        end
        if (arm_stb) armed <= 1'b1;
      end
    end
  end

  p_tc_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> $past(armed));
  p_post_term_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && phase == PH_POST) |-> (stop && !armed));
  p_pre_term_runs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && phase == PH_PRE) |-> (armed && !stop));
  p_trig_after_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(armed) && $past(phase == PH_PRE) && phase == PH_POST) |-> $past(pre_done));
  p_disarm_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (disarm_stb && armed) |=> (stop && !armed));
  p_load_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && load_stb && !disarm_stb) |=> ((phase == PH_PRE) == $past(pre_mode)));
endmodule

// File: rtl/scan_counter.sv
module scan_counter #(
  parameter int unsigned CNT_W = scnt_pkg::SCNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] load_data,
  input  logic             wr_post,
  input  logic             wr_pre,
  input  logic             load_stb,
  input  logic             arm_stb,
  input  logic             disarm_stb,
  input  logic             pre_mode,
  input  logic             scan_end,
  input  logic             trigger,
  output logic             acq_active,
  output logic             tc_pulse,
  output logic             stop_req
);
  logic [CNT_W-1:0] val_post, val_pre, cnt;
  logic             cnt_zero, ld, ld_sel_pre, dec;

  scnt_load_regs #(.W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_data(load_data),
    .wr_en({wr_pre, wr_post}), .val_post(val_post), .val_pre(val_pre)
  );

  scnt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ld(ld),
    .ld_val(ld_sel_pre ? val_pre : val_post),
    .dec(dec), .cnt(cnt), .zero(cnt_zero)
  );

  scnt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .arm_stb(arm_stb),
    .disarm_stb(disarm_stb), .pre_mode(pre_mode), .scan_end(scan_end),
    .trigger(trigger), .cnt_zero(cnt_zero), .ld(ld), .ld_sel_pre(ld_sel_pre),
    .dec(dec), .armed(acq_active), .tc(tc_pulse), .stop(stop_req)
  );

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!acq_active && !load_stb) |=> (cnt == $past(cnt)));
  p_armed_load_ign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_active && load_stb && !scan_end && !trigger) |=> (cnt == $past(cnt)));
endmodule

// File: tb/scan_counter_tb.sv
module scan_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] load_data = '0;
  logic        wr_post = 0, wr_pre = 0, load_stb = 0, arm_stb = 0, disarm_stb = 0;
  logic        pre_mode = 0, scan_end = 0, trigger = 0;
  logic        acq_active, tc_pulse, stop_req;

  int n_chk = 0, n_fail = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    done = 0;

  always #5 clk = ~clk;

  scan_counter u_dut (
    .clk(clk), .rst_n(rst_n), .load_data(load_data), .wr_post(wr_post),
    .wr_pre(wr_pre), .load_stb(load_stb), .arm_stb(arm_stb),
    .disarm_stb(disarm_stb), .pre_mode(pre_mode), .scan_end(scan_end),
    .trigger(trigger), .acq_active(acq_active), .tc_pulse(tc_pulse),
    .stop_req(stop_req)
  );

  // event codes: 1 = tc only, 2 = stop only, 3 = tc and stop
  task automatic expect_ev(int code, string tag);
    exp_q.push_back(code);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && (tc_pulse || stop_req)) begin
      int got;
      got = {30'd0, stop_req, tc_pulse};
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected event: actual %0d expected none (R2/R7)", got);
      end else begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (got != e) begin
          n_fail++;
          $display("FAIL %s: event actual %0d expected %0d", t, got, e);
        end
      end
    end
  end

  task automatic chk_active(logic e, string tag);
    n_chk++;
    if (acq_active !== e) begin
      n_fail++;
      $display("FAIL %s: acq_active actual %b expected %b", tag, acq_active, e);
    end
  endtask

  task automatic wr(bit pre, int val);
    @(negedge clk);
    load_data = val[23:0];
    wr_pre = pre; wr_post = !pre;
    @(negedge clk);
    wr_pre = 0; wr_post = 0;
  endtask

  task automatic load_arm(bit pre, bit do_load, bit do_arm);
    @(negedge clk);
    pre_mode = pre; load_stb = do_load; arm_stb = do_arm;
    @(negedge clk);
    load_stb = 0; arm_stb = 0;
  endtask

  task automatic scan();
    @(negedge clk); scan_end = 1;
    @(negedge clk); scan_end = 0;
  endtask

  task automatic trig();
    @(negedge clk); trigger = 1;
    @(negedge clk); trigger = 0;
  endtask

  task automatic disarm();
    @(negedge clk); disarm_stb = 1;
    @(negedge clk); disarm_stb = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk_active(0, "R1");
    n_chk++;
    if (tc_pulse !== 0 || stop_req !== 0) begin
      n_fail++;
      $display("FAIL R1: tc/stop actual %b%b expected 00", tc_pulse, stop_req);
    end

    // R2 R3 R9: posttrigger, 3 scans, load and arm together
    wr(0, 2);
    load_arm(0, 1, 1);
    chk_active(1, "R9");
    scan(); scan();
    chk_active(1, "R2");
    expect_ev(3, "R3");
    scan();
    chk_active(0, "R3");

    // R7: scans while idle are ignored
    scan(); scan();
    chk_active(0, "R7");

    // R2 boundary: start value zero gives one scan
    wr(0, 0);
    load_arm(0, 1, 1);
    expect_ev(3, "R2");
    scan();
    chk_active(0, "R2");

    // R8: load while armed is ignored
    wr(0, 1);
    load_arm(0, 1, 1);
    wr(0, 0);
    load_arm(0, 1, 0);
    scan();
    chk_active(1, "R8");
    expect_ev(3, "R8");
    scan();
    chk_active(0, "R8");

    // R4 R5 R9: pretrigger mode
    wr(1, 1);
    wr(0, 2);
    load_arm(1, 1, 1);
    trig();              // early trigger, ignored (R5)
    scan();
    expect_ev(1, "R4");
    scan();
    chk_active(1, "R4");
    scan();
    expect_ev(1, "R5");
    scan();
    chk_active(1, "R5");
    trig();              // accepted: switch to posttrigger count of 3
    scan(); scan();
    chk_active(1, "R5");
    expect_ev(3, "R5");
    scan();
    chk_active(0, "R5");

    // R6: disarm mid-run
    wr(0, 5);
    load_arm(0, 1, 1);
    scan();
    expect_ev(2, "R6");
    disarm();
    chk_active(0, "R6");
    scan(); scan();
    trig();
    chk_active(0, "R6");

    repeat (3) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2: pending events actual %0d expected 0", exp_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule